// File: doc/BRIEF.md
# Glitch-Free Four-Source Clock Switch

This block picks one of four free-running source clocks and drives it out as the processor and bus clock. A 2-bit select code, written by software into a configuration field, names the wanted source. When the code changes, the block hands the output over from the old source to the new one by itself, as soon as it can do so safely. The output never carries a runt pulse or a shortened high or low phase.

Each source has its own lane in that source's clock domain. A lane asks for the output only when the code names it and no other lane is active or on its way to becoming active. The request passes through a synchronizer clocked by the lane's own clock. The lane's enable flop is clocked on that clock's falling edge, so the enable only moves while the source is low. The outgoing lane switches off while its clock is low. Only after that can the incoming lane switch on, while its own clock is low. The output clock is the OR of the four gated sources. A status pair reports which source currently drives the output and whether any source does.

Top module: `glitch_free_clk_switch`

## Requirements
- R1: Once a handover has settled for select code k (0 to 3), `clk_out` equals `clk_src[k]`, `act_on` is 1 and `act_src` holds k as a plain binary index.
- R2: A handover completes with no software handshake, within four periods of the outgoing source plus four periods of the incoming source after the code changes.
- R3: A lane's enable changes only while that lane's source clock is low. `clk_out` is therefore low whenever `act_src` or `act_on` changes, and a lane switches on only when every other lane is off.
- R4: Every high pulse on `clk_out` lasts at least the shortest high phase, and at most the longest high phase, of the sources taking part in the handover. Every low pulse lasts at least the shortest low phase of those sources.
- R5: At most one source is enabled at any time. Whenever `clk_out` rises, `act_on` is 1.
- R6: If the code changes again before a handover finishes, the newest code wins: the output settles on the last source written and stays there.
- R7: While `rst` (active high, asynchronous) is asserted, source 0 is enabled whatever the code, with `act_src` = 0 and `act_on` = 1. After release with code 0, source 0 keeps driving the output.
- R8: Rewriting the code of the source already in use causes no gap: `act_on` stays 1, `act_src` is unchanged and `clk_out` keeps following that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | N_SRC (4) | Free-running source clocks, bit k is source k |
| rst | input | 1 | Asynchronous reset, active high; selects source 0 |
| sel | input | SEL_W (2) | Binary code of the wanted source |
| clk_out | output | 1 | Switched output clock |
| act_src | output | SEL_W (2) | Index of the source now driving `clk_out` |
| act_on | output | 1 | 1 while some source is enabled, 0 in the gap of a handover |

## Verification
The assertions take for granted that every source clock keeps toggling. A handover can only advance on edges of both the outgoing and the incoming clock. They also assume that reset is asserted once before normal operation, so the enables start from a known one-hot state. The stimulus keeps all four sources running throughout, with unrelated periods, phase offsets and one uneven duty cycle. The select code is changed half-way between integer-nanosecond source edges, so no sample lands on an edge. The pulse-width monitor is paused around any mid-run reset, because an asynchronous reset may legitimately cut a phase short.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    // Default number of source clocks and synchronizer depth.
    localparam int NUM_SRC_DEF    = 4;
    localparam int SYNC_DEPTH_DEF = 2;

    // What each per-source lane hands back to the top level.
    typedef struct packed {
        logic busy;   // lane is enabled or has a request in flight
        logic en;     // lane currently gates its clock onto the output
        logic gclk;   // source clock ANDed with the lane enable
    } lane_out_t;

    // Width of a binary index that can name n sources.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic any_o
);

    logic [DEPTH-1:0] stg;

    if (DEPTH == 1) begin : g_one
        always_ff @(posedge clk or posedge rst) begin
            if (rst) stg <= RST_VAL;
            else     stg <= d;
        end
    end else begin : g_multi
        always_ff @(posedge clk or posedge rst) begin
            if (rst) stg <= {DEPTH{RST_VAL}};
            else     stg <= {stg[DEPTH-2:0], d};
        end
    end

    assign q     = stg[DEPTH-1];
    assign any_o = |stg;

endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
module clksw_lane
    import clksw_pkg::*;
#(
    parameter int IDX        = 0,
    parameter int N_SRC      = NUM_SRC_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] busy_all,
    output lane_out_t        lane_o
);

    localparam logic [N_SRC-1:0] SELF_MASK = N_SRC'(1) << IDX;
    localparam logic             RST_ON    = (IDX == 0);

    logic others_busy;
    logic want;
    logic sync_q;
    logic sync_any;
    logic en_q;

    // A lane may only ask for the output once every other lane is idle.
    assign others_busy = |(busy_all & ~SELF_MASK);
    assign want        = (sel == SEL_W'(IDX)) && !others_busy;

    clksw_sync #(
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (RST_ON)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     (want),
        .q     (sync_q),
        .any_o (sync_any)
    );

    // Falling-edge enable: it can only move while this clock is low.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) en_q <= RST_ON;
        else     en_q <= sync_q;
    end

    assign lane_o.busy = sync_any | en_q;
    assign lane_o.en   = en_q;
    assign lane_o.gclk = clk & en_q;

endmodule

// File: rtl/clksw_merge.sv
`timescale 1ns/1ps
module clksw_merge #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] en_vec,
    input  logic [N_SRC-1:0] gclk_vec,
    output logic             clk_out,
    output logic [SEL_W-1:0] act_src,
    output logic             act_on
);

    assign clk_out = |gclk_vec;
    assign act_on  = |en_vec;

    always_comb begin
        act_src = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (en_vec[k]) act_src = SEL_W'(k);
        end
    end

endmodule

// File: rtl/glitch_free_clk_switch.sv
`timescale 1ns/1ps
module glitch_free_clk_switch
    import clksw_pkg::*;
#(
    parameter int N_SRC      = NUM_SRC_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF,
    localparam int SEL_W     = idx_width(N_SRC)
) (
    input  logic [N_SRC-1:0] clk_src,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_out,
    output logic [SEL_W-1:0] act_src,
    output logic             act_on
);

    lane_out_t        lanes [N_SRC];
    logic [N_SRC-1:0] busy_vec;
    logic [N_SRC-1:0] en_vec;
    logic [N_SRC-1:0] gclk_vec;

    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        clksw_lane #(
            .IDX        (i),
            .N_SRC      (N_SRC),
            .SYNC_DEPTH (SYNC_DEPTH),
            .SEL_W      (SEL_W)
        ) u_lane (
            .clk      (clk_src[i]),
            .rst      (rst),
            .sel      (sel),
            .busy_all (busy_vec),
            .lane_o   (lanes[i])
        );
        assign busy_vec[i] = lanes[i].busy;
        assign en_vec[i]   = lanes[i].en;
        assign gclk_vec[i] = lanes[i].gclk;
    end

    clksw_merge #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) u_merge (
        .en_vec   (en_vec),
        .gclk_vec (gclk_vec),
        .clk_out  (clk_out),
        .act_src  (act_src),
        .act_on   (act_on)
    );

endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input logic [N_SRC-1:0] clk_src,
    input logic             rst,
    input logic [N_SRC-1:0] en_vec,
    input logic [SEL_W-1:0] act_src,
    input logic             act_on
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        localparam logic [N_SRC-1:0] SELF = N_SRC'(1) << i;

        // R5
        one_enable_chk: assert property (@(posedge clk_src[i]) disable iff (rst)
            $onehot0(en_vec));

        // R3
        rise_alone_chk: assert property (@(negedge clk_src[i]) disable iff (rst)
            $rose(en_vec[i]) |-> ((en_vec & ~SELF) == '0));

        // R1
        src_flag_chk: assert property (@(posedge clk_src[i]) disable iff (rst)
            en_vec[i] |-> (act_on && act_src == SEL_W'(i)));

        // R3
        always @(en_vec[i]) begin
            if (!rst) begin
                en_low_phase_chk: assert (!clk_src[i]);
            end
        end
    end

    // R7
    always @(posedge clk_src[0]) begin
        if (rst) begin
            reset_state_chk: assert (act_on && act_src == '0);
        end
    end

endmodule

bind glitch_free_clk_switch clksw_chk #(
    .N_SRC (N_SRC),
    .SEL_W (SEL_W)
) u_chk (
    .clk_src (clk_src),
    .rst     (rst),
    .en_vec  (en_vec),
    .act_src (act_src),
    .act_on  (act_on)
);

// File: tb/tb_glitch_free_clk_switch.sv
`timescale 1ns/1ps
module tb_glitch_free_clk_switch;

    localparam int NS = 4;
    localparam int HI_NS  [NS] = '{5, 7, 11, 9};
    localparam int LO_NS  [NS] = '{5, 7, 11, 17};
    localparam int OFS_NS [NS] = '{0, 3, 1, 2};

    typedef struct packed {
        logic [1:0] code;
        logic [1:0] exp_src;
    } vec_t;

    // Walks all twelve ordered transitions among the four sources.
    localparam vec_t VECS [12] = '{
        '{2'd1, 2'd1}, '{2'd0, 2'd0}, '{2'd2, 2'd2}, '{2'd0, 2'd0},
        '{2'd3, 2'd3}, '{2'd1, 2'd1}, '{2'd2, 2'd2}, '{2'd1, 2'd1},
        '{2'd3, 2'd3}, '{2'd2, 2'd2}, '{2'd3, 2'd3}, '{2'd0, 2'd0}
    };

    logic       clk;
    logic       c0, c1, c2, c3;
    logic [3:0] clk_src;
    logic       rst;
    logic [1:0] sel;
    logic       clk_out;
    logic [1:0] act_src;
    logic       act_on;

    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 0;
    bit         mon_en = 0;
    logic [3:0] mon_mask = 4'b0001;
    int         cur = 0;
    realtime    t_rise = -1.0;
    realtime    t_fall = -1.0;

    assign clk_src = {c3, c2, c1, c0};

    glitch_free_clk_switch dut (
        .clk_src (clk_src),
        .rst     (rst),
        .sel     (sel),
        .clk_out (clk_out),
        .act_src (act_src),
        .act_on  (act_on)
    );

    // 100 MHz bench clock, edges half-way between integer nanoseconds.
    initial begin
        clk = 1'b0;
        #2.5;
        forever #5 clk = ~clk;
    end

    initial begin c0 = 1'b0; #(OFS_NS[0]); forever begin #(LO_NS[0]) c0 = 1'b1; #(HI_NS[0]) c0 = 1'b0; end end
    initial begin c1 = 1'b0; #(OFS_NS[1]); forever begin #(LO_NS[1]) c1 = 1'b1; #(HI_NS[1]) c1 = 1'b0; end end
    initial begin c2 = 1'b0; #(OFS_NS[2]); forever begin #(LO_NS[2]) c2 = 1'b1; #(HI_NS[2]) c2 = 1'b0; end end
    initial begin c3 = 1'b0; #(OFS_NS[3]); forever begin #(LO_NS[3]) c3 = 1'b1; #(HI_NS[3]) c3 = 1'b0; end end

    function automatic int period(input int k);
        return HI_NS[k] + LO_NS[k];
    endfunction

    function automatic int min_hi(input logic [3:0] m);
        int r = 1000;
        for (int k = 0; k < NS; k++) if (m[k] && HI_NS[k] < r) r = HI_NS[k];
        return r;
    endfunction

    function automatic int max_hi(input logic [3:0] m);
        int r = 0;
        for (int k = 0; k < NS; k++) if (m[k] && HI_NS[k] > r) r = HI_NS[k];
        return r;
    endfunction

    function automatic int min_lo(input logic [3:0] m);
        int r = 1000;
        for (int k = 0; k < NS; k++) if (m[k] && LO_NS[k] < r) r = LO_NS[k];
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_le(input string req, input int act, input int lim);
        n_chk++;
        if (act > lim) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected<=%0d at %0t", req, act, lim, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Pulse-width and gap monitor on the output clock.
    always @(posedge clk_out) begin
        if (mon_en) begin
            if (t_fall >= 0.0) begin
                n_chk++;
                if (($realtime - t_fall) < real'(min_lo(mon_mask)) - 0.001) begin
                    n_err++;
                    $display("FAIL R4: low pulse actual=%0.3f ns expected>=%0d ns", $realtime - t_fall, min_lo(mon_mask));
                end
            end
            chk("R5", int'(act_on), 1);
            chk("R1", int'(clk_src[act_src]), 1);
        end
        t_rise = $realtime;
    end

    always @(negedge clk_out) begin
        if (mon_en && t_rise >= 0.0) begin
            n_chk++;
            if (($realtime - t_rise) < real'(min_hi(mon_mask)) - 0.001 ||
                ($realtime - t_rise) > real'(max_hi(mon_mask)) + 0.001) begin
                n_err++;
                $display("FAIL R4: high pulse actual=%0.3f ns expected %0d..%0d ns", $realtime - t_rise, min_hi(mon_mask), max_hi(mon_mask));
            end
        end
        t_fall = $realtime;
    end

    // R3: the status may only move while the output is low.
    always @(act_src or act_on) begin
        if (mon_en) chk("R3", int'(clk_out), 0);
    end

    task automatic do_switch(input logic [1:0] code, input logic [1:0] exp_src);
        int      bound;
        bit      done;
        realtime t0;
        bound = 4 * (period(cur) + period(int'(code))) + 20;
        @(negedge clk);
        mon_mask = (4'b0001 << cur) | (4'b0001 << code);
        sel  = code;
        t0   = $realtime;
        done = 0;
        for (int n = 0; n < 400 && !done; n++) begin
            @(negedge clk);
            if (act_on && act_src == exp_src) done = 1;
        end
        chk("R1", int'(act_src), int'(exp_src));
        chk_le("R2", int'($realtime - t0), bound);
        mon_mask = 4'b0001 << code;
        cur = int'(code);
        for (int s = 0; s < 8; s++) begin
            #3.3;
            chk("R1", int'(clk_out), int'(clk_src[code]));
        end
    endtask

    initial begin
        int bad;
        bit done;
        rst = 1'b0;
        sel = 2'd0;
        #1 rst = 1'b1;
        #2;
        chk("R7", int'(act_src), 0);
        chk("R7", int'(act_on), 1);
        sel = 2'd2;
        #40;
        chk("R7", int'(act_src), 0);
        sel = 2'd0;
        @(negedge clk) rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7", int'(act_src), 0);
        chk("R7", int'(act_on), 1);
        t_rise = -1.0;
        t_fall = -1.0;
        mon_en = 1;
        cur = 0;

        // Table walk: every ordered transition.
        for (int v = 0; v < 12; v++) begin
            do_switch(VECS[v].code, VECS[v].exp_src);
        end

        // R6: rapid rewrites, newest code must win.
        @(negedge clk);
        mon_mask = 4'b1111;
        sel = 2'd1;
        #3 sel = 2'd2;
        #4 sel = 2'd3;
        done = 0;
        for (int n = 0; n < 200 && !done; n++) begin
            @(negedge clk);
            if (act_on && act_src == 2'd3) done = 1;
        end
        chk("R6", int'(act_src), 3);
        bad = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (!act_on || act_src != 2'd3) bad++;
        end
        chk("R6", bad, 0);
        mon_mask = 4'b1000;
        cur = 3;

        // R8: rewriting the active code causes no gap.
        @(negedge clk);
        sel = 2'd3;
        bad = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (!act_on || act_src != 2'd3 || clk_out != c3) bad++;
        end
        chk("R8", bad, 0);

        // R7: mid-run reset while source 2 drives the output.
        do_switch(2'd2, 2'd2);
        mon_en = 0;
        #1.2 rst = 1'b1;
        #1;
        chk("R7", int'(act_src), 0);
        chk("R7", int'(act_on), 1);
        sel = 2'd0;
        #30;
        @(negedge clk) rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7", int'(act_src), 0);
        bad = 0;
        for (int s = 0; s < 8; s++) begin
            #3.3;
            if (clk_out != c0) bad++;
        end
        chk("R7", bad, 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule